// File: doc/BRIEF.md
# PWM Compare and Action-Qualifier Output Stage

This block turns a running time-base count into two raw PWM waveforms, named A and B. It watches an external counter value, the counting direction, and single-cycle strobes that mark the counter at zero and at its period. Two programmable compare values are matched against the count. Each match is tagged with the direction in which it happened.

Each output keeps its own table, which maps every event in the tick to an action. The action can hold the output, drive it low, drive it high or toggle it. When several events coincide, a fixed priority picks the one action that is applied. A software force can pin either output to a level and overrides all events.

Compare values are written to a shadow copy. That copy becomes active only when the counter passes through zero, so a new duty cycle never cuts into a period that is already running. The counter, dead-band shaping and chopping sit outside this block. The counter presents one new value per clock. `rst_n` arrives already synchronised to `clk`.

Top module: `pwm_action_gen`

## Requirements
- R1: After reset both outputs and both match strobes are low, both active compare values and both shadow values are 0, every action table entry is "hold" and the force is off.
- R2: There are six events per clock, with a fixed index: 0 counter at zero (`tb_zero_i`), 1 counter at period (`tb_prd_i`), 2 compare A while counting up, 3 compare A while counting down, 4 compare B while counting up, 5 compare B while counting down. The action for event k sits in bits [2k+1:2k] of the channel's control word. Bit 12 of that word enables the force and bit 13 gives the forced level.
- R3: The action codes are 00 hold, 01 drive low, 10 drive high and 11 toggle. An output changes on the clock edge that samples the event. It stays unchanged when the selected action is hold.
- R4: A compare match counts as an up event when `cnt_up_i` is 1 and as a down event when it is 0. The two events carry independent actions.
- R5: When several events with non-hold actions occur in one clock, only the one with the highest index from R2 takes effect.
- R6: While the force enable bit is set, the output equals the forced level, whatever events occur. After the force is released, the output keeps that level until the next event with a non-hold action.
- R7: A write to a compare value does not change matching until the clock edge that samples `tb_zero_i` high. On that edge the shadow value becomes active.
- R8: `cmp_a_hit_o` and `cmp_b_hit_o` go high for one cycle, on the edge that samples the count equal to the active compare value, in either direction.
- R9: The write port decodes `wr_addr_i` as follows: 0 selects compare A, 1 compare B, 2 the control word of output A, 3 the control word of output B. A write takes effect on the edge at which `wr_en_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Time-base counter value |
| cnt_up_i | input | 1 | 1 while counting up, 0 while counting down |
| tb_zero_i | input | 1 | Counter-at-zero strobe |
| tb_prd_i | input | 1 | Counter-at-period strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | CNT_W | Write data |
| pwm_a_o | output | 1 | Raw PWM output A |
| pwm_b_o | output | 1 | Raw PWM output B |
| cmp_a_hit_o | output | 1 | Compare A match strobe |
| cmp_b_hit_o | output | 1 | Compare B match strobe |

## Verification
The hardest situation to reach is two events in the same clock that ask for opposite actions. The bench creates it by loading the same value into both compare registers and crossing a zero strobe. It then programs output A so that compare A sets the output and compare B clears it. The shadow rule is checked by writing a new compare value partway through a run. The bench then shows that the old value still matches until a zero strobe, and that the new value matches after it. The force is checked across a release, to show that the output holds its level until a later event.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int NUM_EVT = 6;
  localparam int TBL_W   = 2 * NUM_EVT;
  localparam int EV_ZERO = 0;
  localparam int EV_PRD  = 1;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;
endpackage

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_up_i,
  output logic             evt_up_o,
  output logic             evt_dn_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] active_q, active_d;
  logic             hit_q, hit_d;

  always_comb begin
    shadow_d = wr_i   ? val_i    : shadow_q;
    active_d = load_i ? shadow_q : active_q;
    hit_d    = (cnt_i == active_q);
  end

  assign evt_up_o = hit_d &  dir_up_i;
  assign evt_dn_o = hit_d & ~dir_up_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      hit_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      hit_q    <= hit_d;
    end
  end

  assign hit_o = hit_q;

  // R7: the active value moves only on a zero strobe
  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) |-> $stable(active_q));

  // R8: a strobe implies a directional event one cycle before
  a_r8_hit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(evt_up_o || evt_dn_o));
endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [TBL_W-1:0] tbl_i,
  input  logic             force_en_i,
  input  logic             force_lvl_i,
  output logic             pwm_o
);
  act_e act;
  logic pwm_q, pwm_d, upd;

  // higher index overrides lower: fixed priority
  always_comb begin
    act = ACT_NONE;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (evt_i[k] && (tbl_i[2*k +: 2] != 2'b00)) act = act_e'(tbl_i[2*k +: 2]);
    end
  end

  always_comb begin
    pwm_d = pwm_q;
    upd   = 1'b0;
    if (force_en_i) begin
      pwm_d = force_lvl_i;
      upd   = 1'b1;
    end else begin
      case (act)
        ACT_LOW:  begin pwm_d = 1'b0;   upd = 1'b1; end
        ACT_HIGH: begin pwm_d = 1'b1;   upd = 1'b1; end
        ACT_TOG:  begin pwm_d = ~pwm_q; upd = 1'b1; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pwm_q <= 1'b0;
    else if (upd) pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  // R6: force overrides every event
  a_r6_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_en_i) |-> (pwm_o == $past(force_lvl_i)));

  // R3: hold leaves the output alone
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!force_en_i && act == ACT_NONE) |-> $stable(pwm_o));

  // R3: toggle inverts the output
  a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!force_en_i && act == ACT_TOG) |-> (pwm_o != $past(pwm_o)));
endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_up_i,
  input  logic             tb_zero_i,
  input  logic             tb_prd_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             cmp_a_hit_o,
  output logic             cmp_b_hit_o
);
  localparam int NUM_CH  = 2;
  localparam int FEN_BIT = TBL_W;
  localparam int FLV_BIT = TBL_W + 1;

  logic [CNT_W-1:0]   ctrl_q [NUM_CH];
  logic [CNT_W-1:0]   ctrl_d [NUM_CH];
  logic [NUM_CH-1:0]  evt_up, evt_dn, hit, pwm;
  logic [NUM_EVT-1:0] evt;

  assign evt = {evt_dn[1], evt_up[1], evt_dn[0], evt_up[0], tb_prd_i, tb_zero_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_en_i && (wr_addr_i == 2'(c))),
      .val_i    (wr_data_i),
      .load_i   (tb_zero_i),
      .cnt_i    (cnt_i),
      .dir_up_i (cnt_up_i),
      .evt_up_o (evt_up[c]),
      .evt_dn_o (evt_dn[c]),
      .hit_o    (hit[c])
    );

    always_comb begin
      ctrl_d[c] = ctrl_q[c];
      if (wr_en_i && (wr_addr_i == 2'(c + 2))) ctrl_d[c] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[c] <= '0;
      else        ctrl_q[c] <= ctrl_d[c];
    end

    pwm_aq_channel u_aq (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .tbl_i       (ctrl_q[c][TBL_W-1:0]),
      .force_en_i  (ctrl_q[c][FEN_BIT]),
      .force_lvl_i (ctrl_q[c][FLV_BIT]),
      .pwm_o       (pwm[c])
    );
  end

  assign pwm_a_o     = pwm[0];
  assign pwm_b_o     = pwm[1];
  assign cmp_a_hit_o = hit[0];
  assign cmp_b_hit_o = hit[1];
endmodule

// File: tb/pwm_action_gen_test.sv
module pwm_action_gen_test;
  localparam int W  = 14;
  localparam int NV = 15;
  localparam logic [W-1:0] IDLE = 14'h3FFF;

  logic clk, rst_n, cnt_up, tb_zero, tb_prd, wr_en;
  logic [W-1:0] cnt, wr_data;
  logic [1:0]   wr_addr;
  logic pwm_a, pwm_b, hit_a, hit_b;
  int   n_run, n_fail;
  bit   done;

  pwm_action_gen #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_up_i(cnt_up),
    .tb_zero_i(tb_zero), .tb_prd_i(tb_prd), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_a_o(pwm_a),
    .pwm_b_o(pwm_b), .cmp_a_hit_o(hit_a), .cmp_b_hit_o(hit_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {cnt, up, zero, prd, expA, expB}; cmpA=5 cmpB=8
  localparam logic [W+4:0] VEC [NV] = '{
    {14'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {14'd1,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {14'd4,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {14'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {14'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {14'd8,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {14'd10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {14'd9,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {14'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {14'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {14'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {14'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {14'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {14'd8,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {14'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cnt = IDLE; cnt_up = 1'b1; tb_zero = 1'b0; tb_prd = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic tick(input logic [W-1:0] c, input logic up, input logic z, input logic p);
    @(negedge clk);
    cnt = c; cnt_up = up; tb_zero = z; tb_prd = p;
    @(posedge clk); #1;
    cnt = IDLE; tb_zero = 1'b0; tb_prd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic prev_b;
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cnt = IDLE; cnt_up = 1'b1; tb_zero = 1'b0; tb_prd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(pwm_a == 0 && pwm_b == 0, "R1 outputs low", {pwm_a, pwm_b}, 0);
    chk(hit_a == 0 && hit_b == 0, "R1 strobes low", {hit_a, hit_b}, 0);
    tick(0, 1, 0, 0);
    chk(hit_a == 1 && hit_b == 1, "R1 compare reset to 0 / R8", {hit_a, hit_b}, 3);
    chk(pwm_a == 0 && pwm_b == 0, "R1 tables hold / R3", {pwm_a, pwm_b}, 0);

    // R9 register map and R7 load, then table walk (R2 R3 R4)
    wr(2'd0, 14'd5);
    wr(2'd1, 14'd8);
    tick(0, 1, 1, 0);
    wr(2'd2, 14'h012);
    wr(2'd3, 14'h600);
    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][W+4:5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk(pwm_a == VEC[i][1] && pwm_b == VEC[i][0], "R2 R3 R4 R9 vector",
          {pwm_a, pwm_b}, {VEC[i][1], VEC[i][0]});
    end

    // R8 strobe only on match cycle
    tick(5, 1, 0, 0);
    chk(hit_a == 1 && hit_b == 0, "R8 strobe on match", {hit_a, hit_b}, 2);
    tick(6, 1, 0, 0);
    chk(hit_a == 0, "R8 strobe one cycle", hit_a, 0);

    // R3 toggle, R4 down match ignored when its action is hold
    wr(2'd2, 14'h030);
    tick(5, 1, 0, 0);
    chk(pwm_a == 1, "R3 toggle up", pwm_a, 1);
    tick(5, 1, 0, 0);
    chk(pwm_a == 0, "R3 toggle back", pwm_a, 0);
    tick(5, 0, 0, 0);
    chk(pwm_a == 0, "R4 down event separate", pwm_a, 0);

    // R5 priority: compare B beats compare A
    wr(2'd1, 14'd5);
    tick(0, 1, 1, 0);
    wr(2'd2, 14'h120);
    tick(5, 1, 0, 0);
    chk(pwm_a == 0, "R5 compare B wins", pwm_a, 0);
    wr(2'd2, 14'h020);
    tick(5, 1, 0, 0);
    chk(pwm_a == 1, "R5 compare A alone", pwm_a, 1);

    // R6 force low beats set, then hold after release
    wr(2'd2, 14'h1020);
    tick(5, 1, 0, 0);
    chk(pwm_a == 0, "R6 force wins", pwm_a, 0);
    wr(2'd2, 14'h020);
    tick(7, 1, 0, 0);
    chk(pwm_a == 0, "R6 hold after release", pwm_a, 0);
    tick(5, 1, 0, 0);
    chk(pwm_a == 1, "R6 event after release", pwm_a, 1);

    // R7 shadow: new compare value waits for zero
    wr(2'd2, 14'h030);
    wr(2'd0, 14'd3);
    tick(3, 1, 0, 0);
    chk(pwm_a == 1 && hit_a == 0, "R7 no early match", {pwm_a, hit_a}, 2);
    tick(5, 1, 0, 0);
    chk(pwm_a == 0 && hit_a == 1, "R7 old value active", {pwm_a, hit_a}, 1);
    tick(0, 1, 1, 0);
    tick(3, 1, 0, 0);
    chk(pwm_a == 1 && hit_a == 1, "R7 new value after zero", {pwm_a, hit_a}, 3);

    // R2 period event on output B
    wr(2'd3, 14'h00C);
    prev_b = pwm_b;
    tick(10, 1, 0, 1);
    chk(pwm_b == !prev_b, "R2 period toggle", pwm_b, !prev_b);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule